// File: doc/BRIEF.md
# Conditional Execute Unit with Flags

This block carries out one decoded 16-bit register/operand instruction per clock cycle. Each instruction works on a register file in which the lower half of the register numbers is shared and the upper half is banked by a kernel/user mode input. It also works on a status word that holds negative, zero and carry flags. The unit covers these operation groups: signed and unsigned add and subtract, signed and unsigned compare, the bitwise logic operations, the logical and arithmetic shifts, rotate right, signed and unsigned multiply with a hidden high-half register, a copy from that register, register-to-register move, and byte-immediate loads into the low or high byte.

Most instructions carry a 2-bit condition that is tested against the current flags. When the test fails, the instruction changes nothing. The flags follow a result only when the instruction's flag-update bit is set. The two compare operations are the exception: they always update the flags and never write a register. A debug read port gives the surrounding logic, or a bench, a view of any register in either bank. The status word and the high register are visible at all times.

Top module: `ceu_top`

## Requirements
- R1: After reset every register in both banks, the status word and the high register read zero.
- R2: The condition field is bits 7:6. Its codes are 0 = always, 1 = when Z is set, 2 = when Z is clear, 3 = when C is set. When the test fails, no register, flag or high-register value changes.
- R3: Bit 5 set selects the 4-bit immediate in bits 3:0 as the second operand. It is sign-extended for add (0), sub (25), cmp (4) and mul (12), and zero-extended for every other opcode. Bit 5 clear selects the register numbered by bits 2:0.
- R4: Opcodes in bits 15:11 select the operation. Add (0) and uadd (26) write the sum and set C to the carry out of bit 15. Sub (25) and usub (29) write the difference and set C to the borrow. The status word holds N in bit 15, Z in bit 14 and C in bit 13, and these flags change only when bit 4 (flag update) is 1.
- R5: Cmp (4) and ucmp (27) always update the flags from the first operand minus the second and never write a register. Z means the operands are equal and C is the borrow. N is signed less-than for cmp and unsigned less-than for ucmp.
- R6: And (1), or (14), xor (30) and not (13, which inverts the destination) write their result. With flag update set, N is bit 15, Z marks a zero result and C is cleared.
- R7: Shl (21), shr (22) and ashr (2) shift by the whole 16-bit second operand. Amounts of 16 or more give 0, or copies of the sign bit for ashr. Ror (18) rotates right by the amount modulo 16.
- R8: Mul (12, signed) and umul (28, unsigned) write the low half of the 32-bit product to the destination and the high half to the high register. Mfhi (8) copies the high register into the destination.
- R9: Mov (9) loads bits 7:0 into the low byte and clears the high byte. Movt (11) loads bits 7:0 into the high byte and keeps the low byte. Both always execute and never touch the flags.
- R10: Movr (10) copies the second operand into the destination.
- R11: Numbers 0 to 3 name one shared set of four registers. Numbers 4 to 7 name four user registers when the mode input is 0, and four kernel registers when it is 1. Kernel number 7 is the status word, and a write to it replaces the whole word, taking precedence over a flag update by the same instruction.
- R12: An instruction presented with valid low, or one whose opcode is not listed above, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 16 | Instruction word |
| in_kmode | input | 1 | Register bank select, 1 = kernel |
| dbg_num | input | 3 | Register number for the debug read port |
| dbg_kern | input | 1 | Bank used by the debug read port |
| dbg_data | output | 16 | Debug read data, combinational |
| stat_q | output | 16 | Status word |
| hi_q | output | 16 | High half of the last product |

## Verification
The bench uses the default 16-bit data width. That width makes the edge cases cheap to reach: a register operand of 20 pushes shift amounts past the word size, 0xFFFF squared fills the high register, and a signed product of two small values sign-fills the upper half. With 16 bits, the flag positions also coincide with the status word layout, so a kernel-mode move into the status register can show that the whole-word write wins over the flag update.

// File: rtl/ceu_pkg.sv
package ceu_pkg;

    localparam int IW  = 16;
    localparam int OPW = 5;
    localparam int RNW = 3;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_AND  = 5'd1,
        OP_ASHR = 5'd2,
        OP_CMP  = 5'd4,
        OP_MFHI = 5'd8,
        OP_MOV  = 5'd9,
        OP_MOVR = 5'd10,
        OP_MOVT = 5'd11,
        OP_MUL  = 5'd12,
        OP_NOT  = 5'd13,
        OP_OR   = 5'd14,
        OP_ROR  = 5'd18,
        OP_SHL  = 5'd21,
        OP_SHR  = 5'd22,
        OP_SUB  = 5'd25,
        OP_UADD = 5'd26,
        OP_UCMP = 5'd27,
        OP_UMUL = 5'd28,
        OP_USUB = 5'd29,
        OP_XOR  = 5'd30
    } opc_e;

    typedef enum logic [1:0] {
        CC_ALWAYS  = 2'd0,
        CC_ZERO    = 2'd1,
        CC_NONZERO = 2'd2,
        CC_CARRY   = 2'd3
    } cc_e;

    typedef struct packed {
        opc_e           opc;
        logic [RNW-1:0] dst;
        logic [RNW-1:0] src;
        cc_e            cc;
        logic           imm_sel;
        logic           upd;
        logic [3:0]     imm4;
        logic [7:0]     imm8;
        logic           legal;
        logic           sext_imm;
        logic           no_dst;
        logic           force_fl;
        logic           uncond;
        logic           is_mul;
    } dec_t;

endpackage

// File: rtl/ceu_decode.sv
module ceu_decode
    import ceu_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);

    always_comb begin
        dec          = '0;
        dec.opc      = opc_e'(instr[15:11]);
        dec.dst      = instr[10:8];
        dec.cc       = cc_e'(instr[7:6]);
        dec.imm_sel  = instr[5];
        dec.upd      = instr[4];
        dec.imm4     = instr[3:0];
        dec.imm8     = instr[7:0];
        dec.src      = instr[2:0];
        case (dec.opc)
            OP_ADD, OP_SUB, OP_MUL: begin
                dec.legal    = 1'b1;
                dec.sext_imm = 1'b1;
                dec.is_mul   = (dec.opc == OP_MUL);
            end
            OP_CMP: begin
                dec.legal    = 1'b1;
                dec.sext_imm = 1'b1;
                dec.no_dst   = 1'b1;
                dec.force_fl = 1'b1;
            end
            OP_UCMP: begin
                dec.legal    = 1'b1;
                dec.no_dst   = 1'b1;
                dec.force_fl = 1'b1;
            end
            OP_UMUL: begin
                dec.legal  = 1'b1;
                dec.is_mul = 1'b1;
            end
            OP_MOV, OP_MOVT: begin
                dec.legal  = 1'b1;
                dec.uncond = 1'b1;
                dec.upd    = 1'b0;
            end
            OP_AND, OP_ASHR, OP_MFHI, OP_MOVR, OP_NOT, OP_OR, OP_ROR,
            OP_SHL, OP_SHR, OP_UADD, OP_USUB, OP_XOR: begin
                dec.legal = 1'b1;
            end
            default: begin
                dec.legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ceu_alu.sv
module ceu_alu
    import ceu_pkg::*;
#(
    parameter int DW = 16
) (
    input  opc_e          opc,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] hi,
    input  logic [7:0]    imm8,
    output logic [DW-1:0] res,
    output logic [DW-1:0] hi_new,
    output logic [2:0]    fl
);

    localparam int SW = $clog2(DW);
    localparam int PW = 2 * DW;

    logic [DW:0]     sum;
    logic [DW:0]     dif;
    logic [PW-1:0]   uprod;
    logic [PW-1:0]   sprod;
    logic [PW-1:0]   rot;
    logic [SW-1:0]   amt;
    logic            big;
    logic            slt;
    logic [DW-1:0]   shl_r;
    logic [DW-1:0]   shr_r;
    logic [DW-1:0]   ashr_r;
    logic            f_n;
    logic            f_z;
    logic            f_c;

    assign sum    = {1'b0, a} + {1'b0, b};
    assign dif    = {1'b0, a} - {1'b0, b};
    assign amt    = b[SW-1:0];
    assign big    = |b[DW-1:SW];
    assign shl_r  = big ? '0 : (a << amt);
    assign shr_r  = big ? '0 : (a >> amt);
    assign ashr_r = big ? {DW{a[DW-1]}} : DW'($signed(a) >>> amt);
    assign rot    = {a, a} >> amt;
    assign uprod  = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    assign sprod  = {{DW{a[DW-1]}}, a} * {{DW{b[DW-1]}}, b};
    assign slt    = (a[DW-1] ^ b[DW-1]) ? a[DW-1] : dif[DW-1];

    always_comb begin
        res    = a;
        hi_new = hi;
        f_c    = 1'b0;
        case (opc)
            OP_ADD, OP_UADD: begin
                res = sum[DW-1:0];
                f_c = sum[DW];
            end
            OP_SUB, OP_USUB, OP_CMP, OP_UCMP: begin
                res = dif[DW-1:0];
                f_c = dif[DW];
            end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_SHL:  res = shl_r;
            OP_SHR:  res = shr_r;
            OP_ASHR: res = ashr_r;
            OP_ROR:  res = rot[DW-1:0];
            OP_MUL: begin
                res    = sprod[DW-1:0];
                hi_new = sprod[PW-1:DW];
            end
            OP_UMUL: begin
                res    = uprod[DW-1:0];
                hi_new = uprod[PW-1:DW];
            end
            OP_MFHI: res = hi;
            OP_MOVR: res = b;
            OP_MOV:  res = {{(DW-8){1'b0}}, imm8};
            OP_MOVT: res = {imm8, a[DW-9:0]};
            default: res = a;
        endcase

        f_z = (res == '0);
        case (opc)
            OP_CMP:  f_n = slt;
            OP_UCMP: f_n = dif[DW];
            default: f_n = res[DW-1];
        endcase
        fl = {f_n, f_z, f_c};
    end

endmodule

// File: rtl/ceu_regs.sv
module ceu_regs
    import ceu_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NRP = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RNW-1:0] wnum,
    input  logic           wkern,
    input  logic [DW-1:0]  wdata,
    input  logic           fl_we,
    input  logic [2:0]     fl_in,
    input  logic [RNW-1:0] rnum  [NRP],
    input  logic           rkern [NRP],
    output logic [DW-1:0]  rdata [NRP],
    output logic [DW-1:0]  stat
);

    localparam int NARCH = 1 << RNW;
    localparam int HALF  = NARCH / 2;
    localparam int NPHYS = NARCH + HALF - 1;
    localparam int PIW   = $clog2(NPHYS + 1);

    logic [DW-1:0] gpr [NPHYS];

    function automatic logic [PIW-1:0] phys(input logic [RNW-1:0] n, input logic k);
        if (k && (n >= RNW'(HALF)))
            return PIW'(n) + PIW'(HALF);
        else
            return PIW'(n);
    endfunction

    function automatic logic is_stat(input logic [RNW-1:0] n, input logic k);
        return k && (n == RNW'(NARCH - 1));
    endfunction

    generate
        for (genvar g = 0; g < NRP; g++) begin : g_rd
            assign rdata[g] = is_stat(rnum[g], rkern[g]) ? stat
                                                         : gpr[phys(rnum[g], rkern[g])];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) gpr[i] <= '0;
            stat <= '0;
        end else begin
            if (we && !is_stat(wnum, wkern))
                gpr[phys(wnum, wkern)] <= wdata;
            if (we && is_stat(wnum, wkern))
                stat <= wdata;
            else if (fl_we)
                stat[DW-1 -: 3] <= fl_in;
        end
    end

endmodule

// File: rtl/ceu_top.sv
module ceu_top
    import ceu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [IW-1:0]  in_instr,
    input  logic           in_kmode,
    input  logic [RNW-1:0] dbg_num,
    input  logic           dbg_kern,
    output logic [DW-1:0]  dbg_data,
    output logic [DW-1:0]  stat_q,
    output logic [DW-1:0]  hi_q
);

    localparam int NRP   = 3;
    localparam int ZBIT  = DW - 2;
    localparam int CBIT  = DW - 3;

    dec_t           dec;
    logic [RNW-1:0] rp_num  [NRP];
    logic           rp_kern [NRP];
    logic [DW-1:0]  rp_data [NRP];
    logic [DW-1:0]  op_a;
    logic [DW-1:0]  op_b;
    logic [DW-1:0]  imm_ext;
    logic [DW-1:0]  alu_res;
    logic [DW-1:0]  hi_new;
    logic [2:0]     alu_fl;
    logic           cond_ok;
    logic           exec;
    logic           rf_we;
    logic           fl_we;

    ceu_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    assign rp_num[0]  = dec.dst;
    assign rp_num[1]  = dec.src;
    assign rp_num[2]  = dbg_num;
    assign rp_kern[0] = in_kmode;
    assign rp_kern[1] = in_kmode;
    assign rp_kern[2] = dbg_kern;

    assign imm_ext = dec.sext_imm ? {{(DW-4){dec.imm4[3]}}, dec.imm4}
                                  : {{(DW-4){1'b0}}, dec.imm4};
    assign op_a     = rp_data[0];
    assign op_b     = dec.imm_sel ? imm_ext : rp_data[1];
    assign dbg_data = rp_data[2];

    always_comb begin
        case (dec.cc)
            CC_ALWAYS:  cond_ok = 1'b1;
            CC_ZERO:    cond_ok = stat_q[ZBIT];
            CC_NONZERO: cond_ok = !stat_q[ZBIT];
            default:    cond_ok = stat_q[CBIT];
        endcase
    end

    assign exec  = in_valid && dec.legal && (dec.uncond || cond_ok);
    assign rf_we = exec && !dec.no_dst;
    assign fl_we = exec && (dec.force_fl || dec.upd);

    ceu_alu #(.DW(DW)) u_alu (
        .opc    (dec.opc),
        .a      (op_a),
        .b      (op_b),
        .hi     (hi_q),
        .imm8   (dec.imm8),
        .res    (alu_res),
        .hi_new (hi_new),
        .fl     (alu_fl)
    );

    ceu_regs #(.DW(DW), .NRP(NRP)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wnum  (dec.dst),
        .wkern (in_kmode),
        .wdata (alu_res),
        .fl_we (fl_we),
        .fl_in (alu_fl),
        .rnum  (rp_num),
        .rkern (rp_kern),
        .rdata (rp_data),
        .stat  (stat_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_q <= '0;
        else if (exec && dec.is_mul)
            hi_q <= hi_new;
    end

endmodule

// File: rtl/ceu_chk.sv
module ceu_chk
    import ceu_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [IW-1:0] in_instr,
    input logic [DW-1:0] stat_q,
    input logic [DW-1:0] hi_q,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b
);

    logic [OPW-1:0]  opc;
    logic            movimm;
    logic            cc_always;
    logic [2*DW-1:0] uprod_chk;

    assign opc       = in_instr[15:11];
    assign movimm    = (opc == OP_MOV) || (opc == OP_MOVT);
    assign cc_always = (in_instr[7:6] == 2'd0);
    assign uprod_chk = {{DW{1'b0}}, op_a} * {{DW{1'b0}}, op_b};

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(stat_q) && $stable(hi_q)));

    a_r2_cond_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !movimm && (in_instr[7:6] == 2'd1) && !stat_q[DW-2])
        |=> ($stable(stat_q) && $stable(hi_q)));

    a_r5_cmp_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opc == OP_CMP) && cc_always)
        |=> (stat_q[DW-2] == $past(op_a == op_b)));

    a_r5_ucmp_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opc == OP_UCMP) && cc_always)
        |=> (stat_q[DW-3] == $past(op_a < op_b)));

    a_r8_umul_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opc == OP_UMUL) && cc_always)
        |=> (hi_q == $past(uprod_chk[2*DW-1:DW])));

    a_r9_mov_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && movimm) |=> $stable(hi_q));

endmodule

bind ceu_top ceu_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_instr (in_instr),
    .stat_q   (stat_q),
    .hi_q     (hi_q),
    .op_a     (op_a),
    .op_b     (op_b)
);

// File: tb/tb_ceu_top.sv
`timescale 1ns/1ps
module tb_ceu_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_instr;
    logic        in_kmode;
    logic [2:0]  dbg_num;
    logic        dbg_kern;
    logic [15:0] dbg_data;
    logic [15:0] stat_q;
    logic [15:0] hi_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ceu_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_instr (in_instr),
        .in_kmode (in_kmode),
        .dbg_num  (dbg_num),
        .dbg_kern (dbg_kern),
        .dbg_data (dbg_data),
        .stat_q   (stat_q),
        .hi_q     (hi_q)
    );

    typedef struct packed {
        logic [15:0] ins;
        logic        km;
        logic [2:0]  cnum;
        logic        ckern;
        logic [15:0] eval;
        logic [15:0] estat;
        logic [3:0]  req;
    } vec_t;

    function automatic logic [15:0] fc(input logic [4:0] op, input logic [2:0] d,
                                       input logic [1:0] cc, input logic i,
                                       input logic s, input logic [3:0] b);
        return {op, d, cc, i, s, b};
    endfunction

    function automatic logic [15:0] fi(input logic [4:0] op, input logic [2:0] d,
                                       input logic [7:0] v);
        return {op, d, v};
    endfunction

    function automatic vec_t mk(input logic [15:0] ins, input logic km, input logic [2:0] cnum,
                                input logic ckern, input logic [15:0] ev,
                                input logic [15:0] es, input logic [3:0] rq);
        return {ins, km, cnum, ckern, ev, es, rq};
    endfunction

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        mk(fi(9, 0, 8'h34),              0, 0, 0, 16'h0034, 16'h0000, 9),   // R9 mov a
        mk(fi(11, 0, 8'h12),             0, 0, 0, 16'h1234, 16'h0000, 9),   // R9 movt a
        mk(fi(9, 1, 8'hFF),              0, 1, 0, 16'h00FF, 16'h0000, 9),
        mk(fc(0, 0, 0, 0, 1, 1),         0, 0, 0, 16'h1333, 16'h0000, 4),   // R4 adds
        mk(fi(9, 2, 8'h01),              0, 2, 0, 16'h0001, 16'h0000, 9),
        mk(fi(11, 2, 8'h80),             0, 2, 0, 16'h8001, 16'h0000, 9),
        mk(fc(0, 2, 0, 0, 1, 2),         0, 2, 0, 16'h0002, 16'h2000, 4),   // R4 carry out
        mk(fc(0, 0, 3, 1, 0, 4'hF),      0, 0, 0, 16'h1332, 16'h2000, 2),   // R2 carry cond, R3 -1
        mk(fc(25, 0, 0, 0, 1, 0),        0, 0, 0, 16'h0000, 16'h4000, 4),   // R4 subs to zero
        mk(fc(0, 1, 2, 1, 0, 5),         0, 1, 0, 16'h00FF, 16'h4000, 2),   // R2 nz false
        mk(fc(0, 1, 1, 1, 0, 5),         0, 1, 0, 16'h0104, 16'h4000, 2),   // R2 z true
        mk(fc(4, 1, 0, 1, 0, 8),         0, 1, 0, 16'h0104, 16'h2000, 5),   // R5 cmp vs -8
        mk(fc(27, 1, 0, 1, 0, 8),        0, 1, 0, 16'h0104, 16'h0000, 5),   // R5 ucmp vs 8
        mk(fc(29, 3, 0, 1, 1, 1),        0, 3, 0, 16'hFFFF, 16'hA000, 4),   // R4 usub borrow
        mk(fc(22, 3, 0, 1, 0, 4),        0, 3, 0, 16'h0FFF, 16'hA000, 7),   // R7 shr
        mk(fi(11, 3, 8'h80),             0, 3, 0, 16'h80FF, 16'hA000, 9),
        mk(fc(2, 3, 0, 1, 1, 4),         0, 3, 0, 16'hF80F, 16'h8000, 7),   // R7 ashr
        mk(fc(18, 3, 0, 1, 0, 4),        0, 3, 0, 16'hFF80, 16'h8000, 7),   // R7 ror
        mk(fc(21, 3, 0, 1, 0, 8),        0, 3, 0, 16'h8000, 16'h8000, 7),   // R7 shl
        mk(fi(9, 4, 8'h14),              0, 4, 0, 16'h0014, 16'h8000, 9),
        mk(fc(21, 1, 0, 0, 1, 4),        0, 1, 0, 16'h0000, 16'h4000, 7),   // R7 shl by 20
        mk(fc(2, 3, 0, 0, 0, 4),         0, 3, 0, 16'hFFFF, 16'h4000, 7),   // R7 ashr by 20
        mk(fi(9, 0, 8'hFF),              0, 0, 0, 16'h00FF, 16'h4000, 9),
        mk(fc(12, 0, 0, 1, 0, 4'hE),     0, 0, 0, 16'hFE02, 16'h4000, 8),   // R8 mul by -2
        mk(fc(8, 2, 0, 0, 0, 0),         0, 2, 0, 16'hFFFF, 16'h4000, 8),   // R8 mfhi
        mk(fc(28, 3, 0, 0, 1, 3),        0, 3, 0, 16'h0001, 16'h0000, 8),   // R8 umuls
        mk(fc(8, 1, 0, 0, 0, 0),         0, 1, 0, 16'hFFFE, 16'h0000, 8),
        mk(fc(1, 2, 0, 1, 1, 4'hF),      0, 2, 0, 16'h000F, 16'h0000, 6),   // R6 and, R3 zero-ext
        mk(fc(14, 2, 0, 0, 1, 1),        0, 2, 0, 16'hFFFF, 16'h8000, 6),   // R6 or
        mk(fc(30, 2, 0, 0, 1, 2),        0, 2, 0, 16'h0000, 16'h4000, 6),   // R6 xor
        mk(fc(13, 2, 0, 0, 1, 0),        0, 2, 0, 16'hFFFF, 16'h8000, 6),   // R6 not
        mk(fc(10, 5, 0, 0, 0, 2),        0, 5, 0, 16'hFFFF, 16'h8000, 10),  // R10 movr
        mk(fi(9, 5, 8'h22),              1, 5, 1, 16'h0022, 16'h8000, 11),  // R11 kernel bank
        mk(fc(10, 7, 0, 0, 0, 0),        1, 7, 1, 16'hFE02, 16'hFE02, 11),  // R11 status write
        mk(fc(10, 7, 0, 0, 1, 1),        1, 7, 1, 16'hFFFE, 16'hFFFE, 11),  // R11 write beats flags
        mk(fc(26, 0, 0, 1, 1, 4'hF),     0, 0, 0, 16'hFE11, 16'h9FFE, 4),   // R4 uadd
        mk(fc(0, 0, 0, 0, 1, 2),         0, 0, 0, 16'hFE10, 16'hBFFE, 4)    // R4 add carry
    };

    task automatic check(input logic [15:0] act, input logic [15:0] exp,
                         input int rq, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] ins, input logic km, input logic v);
        @(negedge clk);
        in_instr = ins;
        in_kmode = km;
        in_valid = v;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic peek(input logic [2:0] n, input logic k);
        dbg_num  = n;
        dbg_kern = k;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_instr = '0;
        in_kmode = 1'b0;
        dbg_num  = '0;
        dbg_kern = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(3'd0, 1'b0); check(dbg_data, 16'h0000, 1, "R1 reg a after reset");
        peek(3'd5, 1'b1); check(dbg_data, 16'h0000, 1, "R1 kernel sp after reset");
        check(stat_q, 16'h0000, 1, "R1 status after reset");
        check(hi_q,   16'h0000, 1, "R1 hi after reset");

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].ins, VECS[k].km, 1'b1);
            peek(VECS[k].cnum, VECS[k].ckern);
            check(dbg_data, VECS[k].eval,  int'(VECS[k].req), $sformatf("vector %0d register", k));
            check(stat_q,   VECS[k].estat, int'(VECS[k].req), $sformatf("vector %0d status", k));
        end

        // R8 hi holds the last unsigned product high half
        check(hi_q, 16'hFFFE, 8, "R8 hi after umul");

        // R11 user bank untouched by kernel writes
        peek(3'd5, 1'b0); check(dbg_data, 16'hFFFF, 11, "R11 user f kept");
        peek(3'd7, 1'b0); check(dbg_data, 16'h0000, 11, "R11 user h separate from status");
        peek(3'd4, 1'b1); check(dbg_data, 16'h0000, 11, "R11 kernel ip untouched");

        // R12 valid low has no effect
        apply(fi(9, 0, 8'h00), 1'b0, 1'b0);
        peek(3'd0, 1'b0); check(dbg_data, 16'hFE10, 12, "R12 valid low reg a");
        check(stat_q, 16'hBFFE, 12, "R12 valid low status");

        // R12 unlisted opcode has no effect
        apply(fc(3, 0, 0, 0, 1, 0), 1'b0, 1'b1);
        peek(3'd0, 1'b0); check(dbg_data, 16'hFE10, 12, "R12 unlisted opcode reg a");
        check(stat_q, 16'hBFFE, 12, "R12 unlisted opcode status");
        check(hi_q, 16'hFFFE, 12, "R12 unlisted opcode hi");

        // R9 movt runs even when bits 7:6 look like a false condition
        apply(fi(11, 1, 8'h40), 1'b0, 1'b1);
        peek(3'd1, 1'b0); check(dbg_data, 16'h40FE, 9, "R9 movt unconditional");
        check(stat_q, 16'hBFFE, 9, "R9 movt flags kept");

        // R1 reset in mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        #1;
        peek(3'd1, 1'b0); check(dbg_data, 16'h0000, 1, "R1 mid-run reset reg b");
        check(stat_q, 16'h0000, 1, "R1 mid-run reset status");
        check(hi_q,   16'h0000, 1, "R1 mid-run reset hi");
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule